// File: doc/BRIEF.md
# Boot ROM Remap Controller

This block handles the start-up of a processor that comes out of reset fetching code from a byte-wide boot ROM. The processor's reset vector and its interrupt vector sit at the same address. While reset is held, the block drives a strap that selects narrow (8-bit) code fetch. After reset it routes the shared vector window to the boot ROM, so the first instructions come from ROM.

Once the boot code has set up DRAM and copied its handlers there, software writes the command port with the remap bit set. From the next cycle on, the vector window selects the 64-bit DRAM. The switch is one-way: only another hardware reset brings the ROM back over the vectors.

The ROM also stays visible at a separate alias window at all times, so its contents can still be read after the remap. The normal DRAM window always selects DRAM. All other addresses select neither device.

Top module: `boot_remap_ctrl`

## Requirements
- R1: While `rst` is high, `narrow_strap` is high.
- R2: After `rst` goes low, `narrow_strap` stays high for STRAP_HOLD (default 4) more rising edges, goes low at the STRAP_HOLD-th edge, and then stays low until the next reset.
- R3: After reset, an address in the vector window (default 0xFFFF0000–0xFFFFFFFF) asserts `rom_cs` and deasserts `dram_cs`.
- R4: A `cmd_wr` pulse with `cmd_wdata` bit REMAP_BIT (default bit 0) set makes vector-window addresses assert `dram_cs` and deassert `rom_cs`, starting with the cycle after the write edge.
- R5: Once remapped, command writes with the remap bit clear leave the vector window on DRAM. Only `rst` returns the window to the ROM.
- R6: A command write with the remap bit clear, made before any remap, leaves the vector window on the ROM.
- R7: The ROM alias window (default 0xF0000000–0xF000FFFF) asserts `rom_cs` only, whether or not the remap has happened.
- R8: The DRAM window (default 0x00000000–0x007FFFFF) asserts `dram_cs` only. An address in none of the three windows asserts neither select.
- R9: For any vector-window address, exactly one of `rom_cs` and `dram_cs` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W (32) | Processor address of the current access |
| cmd_wr | input | 1 | Command-port write strobe, one cycle |
| cmd_wdata | input | CMD_W (8) | Command-port write data; bit REMAP_BIT requests the remap |
| rom_cs | output | 1 | Boot ROM chip select, combinational from the address |
| dram_cs | output | 1 | DRAM chip select, combinational from the address |
| narrow_strap | output | 1 | Narrow code-fetch strap to the processor |

## Verification
The selects follow `cpu_addr` in the same cycle. The remap state they depend on changes one edge after a command write. The strap follows `rst` at once and falls STRAP_HOLD edges after reset is released.

The bench drives its inputs on the falling edge and compares all three outputs a short delay later. Its reference model updates its own state only at the rising edge. As a result, a write is seen in the selects exactly one cycle later, and any early or late strap release shows up as a mismatch on a specific cycle.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_VEC   = 2'd1,
        RG_ALIAS = 2'd2,
        RG_MAIN  = 2'd3
    } region_e;

    typedef struct packed {
        logic rom;
        logic dram;
    } chipsel_t;

    // Route one decoded region to the two device selects.
    function automatic chipsel_t route(region_e rg, logic remapped);
        chipsel_t cs;
        cs = '0;
        unique case (rg)
            RG_VEC:   begin cs.rom = ~remapped; cs.dram = remapped; end
            RG_ALIAS: cs.rom  = 1'b1;
            RG_MAIN:  cs.dram = 1'b1;
            default:  cs = '0;
        endcase
        return cs;
    endfunction

endpackage

// File: rtl/strap_timer.sv
module strap_timer #(
    parameter int unsigned HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    output logic strap
);
    localparam int unsigned CNT_W = $clog2(HOLD + 1);

    logic [CNT_W-1:0] left_q;
    logic             held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= CNT_W'(HOLD);
            held_q <= 1'b1;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            held_q <= (left_q > CNT_W'(1));
        end
    end

    assign strap = rst | held_q;

    AST_STRAP_SET_BY_RESET: assert property (@(posedge clk) rst |=> held_q); // R1
    AST_STRAP_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
        !held_q |=> !held_q); // R2

endmodule

// File: rtl/remap_latch.sv
module remap_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    output logic remapped
);
    always_ff @(posedge clk) begin
        if (rst)          remapped <= 1'b0;
        else if (set_req) remapped <= 1'b1;
    end

    AST_REMAP_TAKES: assert property (@(posedge clk) disable iff (rst)
        set_req |=> remapped); // R4
    AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (rst)
        remapped |=> remapped); // R5
    AST_NO_SPURIOUS_REMAP: assert property (@(posedge clk) disable iff (rst)
        (!remapped && !set_req) |=> !remapped); // R6

endmodule

// File: rtl/vector_decoder.sv
module vector_decoder
    import bootmap_pkg::*;
#(
    parameter int unsigned     ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE  = 32'hFFFF_0000,
    parameter int unsigned     VEC_LOG2    = 16,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'hF000_0000,
    parameter int unsigned     ALIAS_LOG2  = 16,
    parameter logic [ADDR_W-1:0] MAIN_BASE = 32'h0000_0000,
    parameter int unsigned     MAIN_LOG2   = 23
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              remapped,
    output region_e           region,
    output chipsel_t          cs
);
    localparam logic [ADDR_W-1:0] VEC_TAG   = VEC_BASE >> VEC_LOG2;
    localparam logic [ADDR_W-1:0] ALIAS_TAG = ALIAS_BASE >> ALIAS_LOG2;
    localparam logic [ADDR_W-1:0] MAIN_TAG  = MAIN_BASE >> MAIN_LOG2;

    logic hit_vec, hit_alias, hit_main;

    always_comb begin
        hit_vec   = (addr >> VEC_LOG2)   == VEC_TAG;
        hit_alias = (addr >> ALIAS_LOG2) == ALIAS_TAG;
        hit_main  = (addr >> MAIN_LOG2)  == MAIN_TAG;
        // Vector window wins over the others if windows ever overlap.
        if (hit_vec)        region = RG_VEC;
        else if (hit_alias) region = RG_ALIAS;
        else if (hit_main)  region = RG_MAIN;
        else                region = RG_NONE;
        cs = route(region, remapped);
    end

endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
    import bootmap_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       CMD_W      = 8,
    parameter int unsigned       REMAP_BIT  = 0,
    parameter int unsigned       STRAP_HOLD = 4,
    parameter logic [ADDR_W-1:0] VEC_BASE   = 32'hFFFF_0000,
    parameter int unsigned       VEC_LOG2   = 16,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'hF000_0000,
    parameter int unsigned       ALIAS_LOG2 = 16,
    parameter logic [ADDR_W-1:0] MAIN_BASE  = 32'h0000_0000,
    parameter int unsigned       MAIN_LOG2  = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic              rom_cs,
    output logic              dram_cs,
    output logic              narrow_strap
);
    logic     remap_req;
    logic     remapped;
    logic     unused_cmd_bits;
    region_e  region;
    chipsel_t cs;

    assign remap_req       = cmd_wr & cmd_wdata[REMAP_BIT];
    assign unused_cmd_bits = ^cmd_wdata;

    strap_timer #(.HOLD(STRAP_HOLD)) u_strap (
        .clk   (clk),
        .rst   (rst),
        .strap (narrow_strap)
    );

    remap_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .set_req  (remap_req),
        .remapped (remapped)
    );

    vector_decoder #(
        .ADDR_W    (ADDR_W),
        .VEC_BASE  (VEC_BASE),
        .VEC_LOG2  (VEC_LOG2),
        .ALIAS_BASE(ALIAS_BASE),
        .ALIAS_LOG2(ALIAS_LOG2),
        .MAIN_BASE (MAIN_BASE),
        .MAIN_LOG2 (MAIN_LOG2)
    ) u_dec (
        .addr     (cpu_addr),
        .remapped (remapped),
        .region   (region),
        .cs       (cs)
    );

    assign rom_cs  = cs.rom;
    assign dram_cs = cs.dram;

    AST_VEC_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        (region == RG_VEC) |-> $onehot({rom_cs, dram_cs})); // R9
    AST_ALIAS_ROM_ONLY: assert property (@(posedge clk) disable iff (rst)
        (region == RG_ALIAS) |-> (rom_cs && !dram_cs)); // R7

endmodule

// File: tb/boot_remap_ctrl_tb.sv
module boot_remap_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cpu_addr = 32'h0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_wdata = 8'h0;
    logic        rom_cs, dram_cs, narrow_strap;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    bit m_remap = 0;
    int m_left = HOLD;
    bit m_strap = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_remap_ctrl dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cmd_wr(cmd_wr),
        .cmd_wdata(cmd_wdata), .rom_cs(rom_cs), .dram_cs(dram_cs),
        .narrow_strap(narrow_strap)
    );

    function automatic bit in_win(longint a, longint lo, longint size);
        return (a >= lo) && (a < lo + size);
    endfunction

    task automatic step(input logic r, input logic [31:0] a, input logic w,
                        input logic [7:0] d, input string tag);
        bit exp_rom, exp_dram, exp_strap;
        longint la;
        @(negedge clk);
        rst = r; cpu_addr = a; cmd_wr = w; cmd_wdata = d;
        #1;
        la = longint'(a);
        exp_rom = 0; exp_dram = 0;
        if (in_win(la, 64'hFFFF0000, 64'h10000)) begin
            exp_rom = !m_remap; exp_dram = m_remap;
        end else if (in_win(la, 64'hF0000000, 64'h10000)) exp_rom = 1;
        else if (in_win(la, 0, 64'h800000)) exp_dram = 1;
        exp_strap = r || m_strap;
        total++;
        if (rom_cs !== exp_rom || dram_cs !== exp_dram || narrow_strap !== exp_strap) begin
            bad++;
            $display("FAIL %s addr=%h got rom=%b dram=%b strap=%b exp rom=%b dram=%b strap=%b",
                     tag, a, rom_cs, dram_cs, narrow_strap, exp_rom, exp_dram, exp_strap);
        end
        @(posedge clk);
        if (r) begin
            m_remap = 0; m_left = HOLD; m_strap = 1;
        end else begin
            if (w && d[0]) m_remap = 1;
            if (m_left > 0) begin
                m_strap = (m_left > 1);
                m_left--;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        // R1: strap held during reset, reset-state decode
        step(1, 32'hFFFFFF00, 0, 8'h00, "R1");
        step(1, 32'hFFFFFF00, 0, 8'h00, "R1");
        // R2/R3: strap release timing while fetching vectors from ROM
        for (int i = 0; i < HOLD + 3; i++)
            step(0, 32'hFFFFFF00 + 32'(i*8), 0, 8'h00, "R2_R3");
        step(0, 32'hF0000010, 0, 8'h00, "R7");
        step(0, 32'h00001000, 0, 8'h00, "R8");
        step(0, 32'h007FFFFC, 0, 8'h00, "R8");
        step(0, 32'h00800000, 0, 8'h00, "R8");
        step(0, 32'h80000000, 0, 8'h00, "R8");
        // R6: write with remap bit clear
        step(0, 32'hFFFF0000, 1, 8'hFE, "R6");
        step(0, 32'hFFFF0000, 0, 8'h00, "R6");
        step(0, 32'hFFFFFFFC, 0, 8'h00, "R9");
        // R4: remap write, then vector goes to DRAM
        step(0, 32'hFFFFFF00, 1, 8'h01, "R4");
        step(0, 32'hFFFFFF00, 0, 8'h00, "R4");
        step(0, 32'hFFFF8000, 0, 8'h00, "R9");
        step(0, 32'hF000FFFC, 0, 8'h00, "R7");
        step(0, 32'h00000000, 0, 8'h00, "R8");
        // R5: clear-bit writes do not undo the remap
        step(0, 32'hFFFFFF00, 1, 8'h00, "R5");
        step(0, 32'hFFFFFF00, 1, 8'hFE, "R5");
        step(0, 32'hFFFFFF00, 0, 8'h00, "R5");
        // R5/R1: a new reset brings ROM back and re-asserts the strap
        step(1, 32'hFFFFFF00, 0, 8'h00, "R1");
        step(1, 32'hFFFFFF00, 0, 8'h00, "R5");
        for (int i = 0; i < HOLD + 2; i++)
            step(0, 32'hFFFFFF00, 0, 8'h00, "R2_R5");
        // R1: reset asserted in the middle of the strap window
        step(1, 32'hFFFFFF00, 0, 8'h00, "R1");
        step(0, 32'hFFFFFF00, 0, 8'h00, "R2");
        step(0, 32'hFFFFFF00, 0, 8'h00, "R2");
        step(1, 32'hFFFFFF00, 1, 8'h01, "R1");
        for (int i = 0; i < HOLD + 2; i++)
            step(0, 32'hFFFFFF00, 0, 8'h00, "R2_R3");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule